// File: doc/BRIEF.md
# Multi-Mode Bus Read Master

This block is the master side of a single-word read transfer. A one-clock start pulse launches a read whose timing is picked at run time by a two-bit mode input. In fixed mode the master holds its request for a set number of clocks and then latches whatever the slave presents, with no reply from the slave. In stretched mode the request is held for as many whole clocks as the slave needs, until the slave raises its completion line. In interlocked mode the master and a slave with no shared clock complete a four-phase request/acknowledge exchange. The acknowledge is brought into the clock domain through a flip-flop synchronizer.

Each cycle has the same shape. The request is held, a one-clock latch-enable strobe is given, and the request stays high for one tail clock after the strobe. Data is captured on the rising or the falling edge of the strobe, chosen when the block is built. A one-clock done pulse marks new data on the output register. In the two modes that wait on the slave, a timeout limit given on a port aborts the cycle and raises a sticky error flag.

Top module: `xrm_read_master`

## Requirements
- R1: While reset is asserted and on release, `req_o`, `latch_en_o`, `done_o` and `err_o` are 0 and `data_o` is all zeros.
- R2: A start pulse is taken only when the block is idle and the synchronized acknowledge is low. A start at any other time has no effect on any output.
- R3: In fixed mode (`mode_i` = 0, and also the spare code 3), `req_o` rises the clock after an accepted start and stays high for `SYNC_CYCLES` wait clocks, one strobe clock and one tail clock. Completion and acknowledge are not looked at.
- R4: In stretched mode (`mode_i` = 1), `req_o` stays high until `complete_i` is sampled high on a wait clock. The strobe follows on the next clock, then one tail clock, then idle.
- R5: In interlocked mode (`mode_i` = 2), the strobe follows the first wait clock on which the acknowledge, delayed by the two-stage synchronizer, is high. After the tail clock `req_o` drops. The block then stays busy until the synchronized acknowledge has gone low.
- R6: With `CAPTURE_ON_FALL` = 0, `data_o` takes `rd_data_i` as sampled at the clock edge that ends the strobe clock. With `CAPTURE_ON_FALL` = 1, it takes the sample at the edge that ends the tail clock.
- R7: `done_o` is high for exactly one clock per completed read: the first clock in which the newly captured word is on `data_o`.
- R8: In stretched or interlocked mode, the cycle aborts with no strobe and no capture if no response has come on the wait clock whose count (starting at 0) equals `tmo_limit_i`. `req_o` drops and `err_o` goes high. `err_o` stays high until the next accepted start. `data_o` keeps its old value.
- R9: `latch_en_o` is high only while `req_o` is high, and never for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock pulse that requests a read |
| mode_i | input | 2 | Timing mode: 0 fixed, 1 stretched, 2 interlocked, 3 fixed |
| tmo_limit_i | input | TMO_W | Last wait clock index before a timeout abort |
| rd_data_i | input | DATA_W | Read data from the slave |
| complete_i | input | 1 | Slave completion (stretched mode) |
| ack_i | input | 1 | Asynchronous slave acknowledge (interlocked mode) |
| req_o | output | 1 | Read strobe / ready request |
| latch_en_o | output | 1 | One-clock latch enable |
| data_o | output | DATA_W | Captured read word |
| done_o | output | 1 | One-clock pulse: new word on `data_o` |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds two copies side by side on the same stimulus, one with `CAPTURE_ON_FALL` = 0 and one with 1. The fixed-mode slave changes its data on every request clock, so the two copies must hold different words, which shows which edge captured. `SYNC_CYCLES` is 3 and `TMO_W` is 5. This keeps timeouts, including a limit of 0, to a few clocks. The interlocked slave is slow to release its acknowledge, so a start can land while the synchronized acknowledge is still high.

// File: rtl/xrm_pkg.sv
`timescale 1ns/1ps
package xrm_pkg;
   typedef enum logic [1:0] {
      XM_FIXED   = 2'd0,
      XM_STRETCH = 2'd1,
      XM_INTLK   = 2'd2,
      XM_SPARE   = 2'd3
   } xrm_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_STROBE,
      ST_TAIL,
      ST_RELEASE
   } xrm_state_e;
endpackage

// File: rtl/xrm_ack_sync.sv
`timescale 1ns/1ps
module xrm_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xrm_ack_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xrm_wait_timer.sv
`timescale 1ns/1ps
module xrm_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("xrm_wait_timer: CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_o <= '0;
      else if (clear_i) count_o <= '0;
      else if (inc_i)   count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/xrm_capture.sv
`timescale 1ns/1ps
module xrm_capture #(
   parameter int DATA_W  = 16,
   parameter bit ON_FALL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);
   logic fire;

   generate
      if (ON_FALL) begin : g_fall
         logic en_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_d <= 1'b0;
            else        en_d <= en_i;
         end
         assign fire = en_d & ~en_i;
      end else begin : g_rise
         assign fire = en_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= fire;
         if (fire) data_o <= data_i;
      end
   end
endmodule

// File: rtl/xrm_read_master.sv
`timescale 1ns/1ps
module xrm_read_master
   import xrm_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int SYNC_CYCLES     = 3,
   parameter int TMO_W           = 8,
   parameter int ACK_STAGES      = 2,
   parameter bit CAPTURE_ON_FALL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              complete_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic              latch_en_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int SYNC_W = $clog2(SYNC_CYCLES + 1) + 1;
   localparam int CNT_W  = (TMO_W > SYNC_W) ? TMO_W : SYNC_W;
   localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_CYCLES - 1);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("xrm_read_master: DATA_W must be positive");
      end
      if (SYNC_CYCLES < 1) begin : g_bad_sync
         $error("xrm_read_master: SYNC_CYCLES must be at least 1");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("xrm_read_master: TMO_W must be positive");
      end
   endgenerate

   xrm_state_e       state_q, state_d;
   xrm_mode_e        mode_q;
   logic             err_q;
   logic             ack_s;
   logic [CNT_W-1:0] wait_cnt;
   logic             take_start;
   logic             tmo_hit;
   logic             fixed_mode;
   logic             slave_resp;

   xrm_ack_sync #(.STAGES(ACK_STAGES)) u_ack_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ack_i),
      .sync_o  (ack_s)
   );

   xrm_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (state_q != ST_WAIT),
      .inc_i   (state_q == ST_WAIT),
      .count_o (wait_cnt)
   );

   xrm_capture #(.DATA_W(DATA_W), .ON_FALL(CAPTURE_ON_FALL)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (latch_en_o),
      .data_i (rd_data_i),
      .data_o (data_o),
      .done_o (done_o)
   );

   assign fixed_mode = (mode_q == XM_FIXED) || (mode_q == XM_SPARE);
   assign slave_resp = (mode_q == XM_STRETCH) ? complete_i :
                       (mode_q == XM_INTLK)   ? ack_s      : 1'b0;
   assign take_start = (state_q == ST_IDLE) && start_i && !ack_s;

   always_comb begin
      state_d = state_q;
      tmo_hit = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (take_start) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (fixed_mode) begin
               if (wait_cnt == SYNC_LAST) state_d = ST_STROBE;
            end else if (slave_resp) begin
               state_d = ST_STROBE;
            end else if (wait_cnt == CNT_W'(tmo_limit_i)) begin
               tmo_hit = 1'b1;
               state_d = (mode_q == XM_INTLK) ? ST_RELEASE : ST_IDLE;
            end
         end
         ST_STROBE: state_d = ST_TAIL;
         ST_TAIL:   state_d = (mode_q == XM_INTLK) ? ST_RELEASE : ST_IDLE;
         ST_RELEASE: begin
            if (!ack_s) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= XM_FIXED;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take_start) begin
            mode_q <= xrm_mode_e'(mode_i);
            err_q  <= 1'b0;
         end else if (tmo_hit) begin
            err_q  <= 1'b1;
         end
      end
   end

   assign req_o      = (state_q == ST_WAIT) || (state_q == ST_STROBE) || (state_q == ST_TAIL);
   assign latch_en_o = (state_q == ST_STROBE);
   assign err_o      = err_q;
endmodule

// File: rtl/xrm_read_master_chk.sv
`timescale 1ns/1ps
module xrm_read_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic ack_s,
   input logic req_o,
   input logic latch_en_o,
   input logic done_o,
   input logic err_o
);
   p_strobe_in_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en_o |-> req_o);

   p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en_o |=> !latch_en_o);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !err_o);

   p_req_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> ($past(start_i) && !$past(ack_s)));
endmodule

bind xrm_read_master xrm_read_master_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .ack_s      (ack_s),
   .req_o      (req_o),
   .latch_en_o (latch_en_o),
   .done_o     (done_o),
   .err_o      (err_o)
);

// File: tb/xrm_read_master_tb_top.sv
`timescale 1ns/1ps
module xrm_ref_model #(
   parameter int DATA_W      = 16,
   parameter int SYNC_CYCLES = 3,
   parameter int TMO_W       = 5,
   parameter bit ON_FALL     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [TMO_W-1:0]  tmo,
   input  logic [DATA_W-1:0] rd,
   input  logic              complete,
   input  logic              ack,
   output logic              req,
   output logic              en,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] data
);
   int ph, cnt, md;
   bit a1, a2, acks, fire;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; cnt = 0; md = 0; a1 = 0; a2 = 0;
         done = 0; err = 0; data = '0;
      end else begin
         acks = a2;
         fire = ON_FALL ? (ph == 3) : (ph == 2);
         done = fire;
         if (fire) data = rd;
         case (ph)
            0: if (start && !acks) begin ph = 1; cnt = 0; md = int'(mode); err = 0; end
            1: begin
               if (md == 0 || md == 3) begin
                  if (cnt == SYNC_CYCLES - 1) ph = 2; else cnt++;
               end else if ((md == 1 && complete) || (md == 2 && acks)) begin
                  ph = 2;
               end else if (cnt == int'(tmo)) begin
                  ph = (md == 2) ? 4 : 0;
                  err = 1;
               end else cnt++;
            end
            2: ph = 3;
            3: ph = (md == 2) ? 4 : 0;
            4: if (!acks) ph = 0;
            default: ph = 0;
         endcase
         a2 = a1;
         a1 = ack;
      end
      req = (ph >= 1 && ph <= 3);
      en  = (ph == 2);
   end
endmodule

module xrm_read_master_tb_top;
   localparam int DW = 16;
   localparam int SC = 3;
   localparam int TW = 5;

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0;
   logic [1:0] mode = 0;
   logic [TW-1:0] tmo = 6;
   logic [DW-1:0] rd = 0;
   logic cmpl = 0;
   logic ack = 0;

   logic req_r, en_r, done_r, err_r; logic [DW-1:0] data_r;
   logic req_f, en_f, done_f, err_f; logic [DW-1:0] data_f;
   logic mreq_r, men_r, mdone_r, merr_r; logic [DW-1:0] mdata_r;
   logic mreq_f, men_f, mdone_f, merr_f; logic [DW-1:0] mdata_f;

   always #4 clk = ~clk;

   xrm_read_master #(.DATA_W(DW), .SYNC_CYCLES(SC), .TMO_W(TW), .CAPTURE_ON_FALL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .tmo_limit_i(tmo),
      .rd_data_i(rd), .complete_i(cmpl), .ack_i(ack), .req_o(req_r), .latch_en_o(en_r),
      .data_o(data_r), .done_o(done_r), .err_o(err_r));

   xrm_read_master #(.DATA_W(DW), .SYNC_CYCLES(SC), .TMO_W(TW), .CAPTURE_ON_FALL(1'b1)) dut_f (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .tmo_limit_i(tmo),
      .rd_data_i(rd), .complete_i(cmpl), .ack_i(ack), .req_o(req_f), .latch_en_o(en_f),
      .data_o(data_f), .done_o(done_f), .err_o(err_f));

   xrm_ref_model #(.DATA_W(DW), .SYNC_CYCLES(SC), .TMO_W(TW), .ON_FALL(1'b0)) ref_r (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tmo(tmo), .rd(rd),
      .complete(cmpl), .ack(ack), .req(mreq_r), .en(men_r), .done(mdone_r), .err(merr_r), .data(mdata_r));

   xrm_ref_model #(.DATA_W(DW), .SYNC_CYCLES(SC), .TMO_W(TW), .ON_FALL(1'b1)) ref_f (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tmo(tmo), .rd(rd),
      .complete(cmpl), .ack(ack), .req(mreq_f), .en(men_f), .done(mdone_f), .err(merr_f), .data(mdata_f));

   // slave behaviour, driven at the falling edge
   int slave_kind = 0;
   int slave_dly = 0;
   logic [DW-1:0] bus_val = 0;
   int sc_cnt = 0;

   always @(negedge clk) begin
      case (slave_kind)
         0: begin
            cmpl = 0; ack = 0; sc_cnt = 0;
            if (req_r) rd = rd + 1'b1; else rd = bus_val;
         end
         1: begin
            ack = 0; rd = bus_val;
            if (req_r) begin
               if (sc_cnt >= slave_dly) cmpl = 1; else sc_cnt++;
            end else begin
               cmpl = 0; sc_cnt = 0;
            end
         end
         default: begin
            cmpl = 0;
            if (req_r && !ack) begin
               if (sc_cnt >= slave_dly) begin ack = 1; rd = bus_val; sc_cnt = 0; end
               else sc_cnt++;
            end else if (!req_r && ack) begin
               if (sc_cnt >= 3) begin ack = 0; rd = 0; sc_cnt = 0; end
               else sc_cnt++;
            end else sc_cnt = 0;
         end
      endcase
   end

   // per-clock comparison against the reference model
   int cyc_checks = 0, cyc_errs = 0, dir_checks = 0, dir_errs = 0;
   int ndone_r = 0, ndone_f = 0, cyc = 0;
   string phase_tag = "R1";
   bit run_done = 0;

   task automatic cmp1(input string sig, input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      cyc_checks++;
      if (got !== exp) begin
         cyc_errs++;
         $display("FAIL %s %s cycle %0d actual %h expected %h", tag, sig, cyc, got, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && cyc > 2) begin
         cmp1("req_r",  phase_tag, DW'(req_r),  DW'(mreq_r));
         cmp1("req_f",  phase_tag, DW'(req_f),  DW'(mreq_f));
         cmp1("en_r",   "R9",      DW'(en_r),   DW'(men_r));
         cmp1("en_f",   "R9",      DW'(en_f),   DW'(men_f));
         cmp1("done_r", "R7",      DW'(done_r), DW'(mdone_r));
         cmp1("done_f", "R7",      DW'(done_f), DW'(mdone_f));
         cmp1("err_r",  "R8",      DW'(err_r),  DW'(merr_r));
         cmp1("err_f",  "R8",      DW'(err_f),  DW'(merr_f));
         cmp1("data_r", "R6",      data_r,      mdata_r);
         cmp1("data_f", "R6",      data_f,      mdata_f);
         if (done_r) ndone_r++;
         if (done_f) ndone_f++;
      end
      if (cyc > 50000 && !run_done) begin
         $display("FAIL watchdog expired at cycle %0d actual hung expected finished", cyc);
         $display("CHECKS %0d ERRORS %0d", cyc_checks + dir_checks + 1, cyc_errs + dir_errs + 1);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      dir_checks++;
      if (got !== exp) begin
         dir_errs++;
         $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      while (req_r || ack) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic run(input int kind, input int md, input logic [DW-1:0] val,
                      input int dly, input int lim, input string tag, input bit extra);
      slave_kind = kind; slave_dly = dly; bus_val = val; tmo = TW'(lim);
      phase_tag = tag;
      @(negedge clk);
      start = 1; mode = 2'(md);
      @(negedge clk);
      start = 0;
      if (extra) begin
         @(negedge clk);
         start = 1;
         @(negedge clk);
         start = 0;
      end
      settle();
   endtask

   initial begin
      int dr, df;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "req_o",      DW'(req_r),  '0);
      chk("R1", "latch_en_o", DW'(en_r),   '0);
      chk("R1", "done_o",     DW'(done_f), '0);
      chk("R1", "err_o",      DW'(err_r),  '0);
      chk("R1", "data_o",     data_f,      '0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 fixed mode with changing data: R6 edge choice visible
      dr = ndone_r; df = ndone_f;
      run(0, 0, 16'h1000, 0, 6, "R3", 0);
      chk("R6", "rise capture", data_r, 16'h1004);
      chk("R6", "fall capture", data_f, 16'h1005);
      chk("R7", "one done rise", DW'(ndone_r - dr), 16'd1);
      chk("R7", "one done fall", DW'(ndone_f - df), 16'd1);

      // R3 spare code behaves as fixed
      run(0, 3, 16'h2000, 0, 6, "R3", 0);
      chk("R3", "spare mode rise", data_r, 16'h2004);
      chk("R3", "spare mode fall", data_f, 16'h2005);

      // R4 stretched mode, slave needs 4 clocks
      run(1, 1, 16'hBEEF, 4, 20, "R4", 0);
      chk("R4", "stretched data", data_r, 16'hBEEF);
      chk("R4", "stretched data fall", data_f, 16'hBEEF);

      // R8 stretched timeout
      dr = ndone_r;
      run(1, 1, 16'h5555, 100, 6, "R8", 0);
      chk("R8", "err set", DW'(err_r), 16'd1);
      chk("R8", "err set fall", DW'(err_f), 16'd1);
      chk("R8", "data kept", data_r, 16'hBEEF);
      chk("R8", "no done", DW'(ndone_r - dr), 16'd0);

      // R5 interlocked read; also clears err (R8)
      run(2, 2, 16'hA5C3, 2, 20, "R5", 0);
      chk("R5", "async data", data_r, 16'hA5C3);
      chk("R5", "async data fall", data_f, 16'hA5C3);
      chk("R8", "err cleared", DW'(err_r), 16'd0);

      // R2 start while busy ignored
      dr = ndone_r;
      run(1, 1, 16'h0F0F, 6, 20, "R2", 1);
      chk("R2", "busy start ignored", DW'(ndone_r - dr), 16'd1);

      // R2 start while synchronized ack still high
      dr = ndone_r;
      slave_kind = 2; slave_dly = 1; bus_val = 16'h3C3C; tmo = TW'(20);
      phase_tag = "R2";
      @(negedge clk); start = 1; mode = 2'd2;
      @(negedge clk); start = 0;
      while (!en_r) @(negedge clk);
      @(negedge clk); @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      chk("R2", "req low in release", DW'(req_r), 16'd0);
      settle();
      chk("R2", "ack-high start ignored", DW'(ndone_r - dr), 16'd1);
      chk("R5", "release data", data_r, 16'h3C3C);

      // R8 interlocked timeout, slave silent
      run(2, 2, 16'h7777, 100, 4, "R8", 0);
      chk("R8", "async err", DW'(err_r), 16'd1);
      chk("R8", "async data kept", data_f, 16'h3C3C);

      // R8 limit of zero
      run(1, 1, 16'h1111, 3, 0, "R8", 0);
      chk("R8", "zero limit err", DW'(err_r), 16'd1);

      // R3 back to fixed after errors
      run(0, 0, 16'h4000, 0, 6, "R3", 0);
      chk("R3", "fixed after err", data_r, 16'h4004);
      chk("R8", "err cleared again", DW'(err_f), 16'd0);

      run_done = 1;
      $display("CHECKS %0d ERRORS %0d", cyc_checks + dir_checks, cyc_errs + dir_errs);
      $finish;
   end
endmodule